// File: doc/BRIEF.md
# Streaming Fully Connected Neuron

This block computes one neuron of a fully connected layer. Activations arrive one per beat on a valid/ready stream. Each accepted activation is multiplied by its own weight, which is read from a weight ROM inside the block. The ROM has a one-cycle synchronous read. The products are summed in Q16.16 fixed point. After the last product a constant bias is added. A ReLU can be enabled at build time. The finished value is then presented together with a completion flag.

A layer is built by placing several instances side by side on one activation stream. All instances share the same timing, so a layer of `N_IN` inputs needs about `N_IN` accepted beats. Each instance gets its own weight seed and its own bias.

The control is a state machine with five states:

- `ST_IDLE`: after reset.
- `ST_PRIME`: one cycle after `start`, with the stream stalled.
- `ST_RUN`: activations are accepted.
- `ST_FINAL`: the last product is folded in and the output is formed.
- `ST_DONE`: the result is held.

It has these transitions:

- Any state goes to `ST_PRIME` on `start`.
- `ST_PRIME` goes to `ST_RUN`.
- `ST_RUN` goes to `ST_FINAL` when the `N_IN`-th beat is accepted.
- `ST_FINAL` goes to `ST_DONE`.
- `ST_DONE` stays there until the next `start`.

Top module: `fc_stream_neuron`

## Requirements
- R1: After reset, `in_ready` and `done` are 0. Whenever `done` is 0, `out_data` is 0.
- R2: The cycle after a `start` pulse is a priming cycle in which `in_ready` is 0. In the following cycle `in_ready` is 1.
- R3: Each product is the signed 64-bit product of activation and weight, arithmetically shifted right by 16 and truncated to 32 bits. Products are summed in a 32-bit register that wraps on overflow. Both operands and the result are two's-complement Q16.16.
- R4: The bias `BIAS` is added exactly once, to the complete sum of all `N_IN` products.
- R5: With `RELU_EN`=1, a negative final value (bit 31 set) is output as 0. With `RELU_EN`=0, the final value is output unchanged, including negative values.
- R6: Only a beat with `in_valid` and `in_ready` both high counts. Beats offered while `in_ready` is 0, and idle gaps between beats, do not change the result.
- R7: `done` rises exactly one cycle after the edge that accepts the `N_IN`-th beat. `in_ready` is 0 from that acceptance on. `done` and `out_data` then hold, whatever the input stream does, until the next `start`.
- R8: A `start` clears the accumulator, `done` and `out_data`. This also applies to a `start` in the middle of an inference, so each result depends only on the beats accepted after the latest `start`.
- R9: Weight k (k = 0 .. `N_IN`-1) is taken from h = (k·40503 + `W_SEED`) mod 2^32. The weight is the sign extension of h bits [16:0], which covers about ±1.0 in Q16.16. ROM entries past `N_IN`, up to the next power of two, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins an inference |
| in_valid | input | 1 | Activation beat is valid |
| in_data | input | 32 | Activation, Q16.16 signed |
| in_ready | output | 1 | Neuron accepts a beat this cycle |
| out_data | output | 32 | Neuron result, Q16.16 signed |
| done | output | 1 | Result in `out_data` is final |

## Verification
The bench builds two instances with `N_IN`=7, `W_SEED`=123 and a bias of -1.5, one with ReLU and one without, both fed by the same stream. With only seven inputs, the ROM is padded to eight entries, and the last-beat handling is reached many times within a short run. Because the two instances differ only in the ReLU setting, negative sums show up directly at the output comparison. Activations near full scale force the 32-bit sum to wrap. Random gaps, beats offered during priming and after completion, and a restart in the middle of an inference exercise the acceptance rules.

// File: rtl/fcn_pkg.sv
package fcn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_RUN,
        ST_FINAL,
        ST_DONE
    } fcn_state_e;

    // Weight generator: sign-extended low 17 bits of a multiplicative hash.
    function automatic logic [31:0] fcn_weight(input int unsigned idx, input int unsigned seed);
        logic [31:0] h;
        h = idx * 32'd40503 + seed;
        return {{15{h[16]}}, h[16:0]};
    endfunction

endpackage

// File: rtl/fcn_weight_rom.sv
module fcn_weight_rom #(
    parameter int N_IN   = 676,
    parameter int W_SEED = 1,
    parameter int DEPTH  = 1024,
    parameter int AW     = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);
    import fcn_pkg::*;

    logic [31:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        if (g < N_IN) begin : g_used
            assign tbl[g] = fcn_weight(g, W_SEED);
        end else begin : g_pad
            assign tbl[g] = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= tbl[rd_addr];
    end

endmodule

// File: rtl/fcn_mac.sv
module fcn_mac (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        take,
    input  logic [31:0] x_in,
    input  logic [31:0] w_in,
    output logic [31:0] sum_next
);
    logic        [31:0] x_cur;
    logic               prime;
    logic        [31:0] acc;
    logic signed [63:0] full;
    logic        [31:0] prod;

    // The weight from the ROM is valid one cycle after take; prime marks that cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_cur <= '0;
            prime <= 1'b0;
            acc   <= '0;
        end else if (clr) begin
            prime <= 1'b0;
            acc   <= '0;
        end else begin
            prime <= take;
            if (take) x_cur <= x_in;
            acc <= sum_next;
        end
    end

    always_comb begin
        full     = $signed(x_cur) * $signed(w_in);
        prod     = 32'(full >>> 16);
        sum_next = prime ? acc + prod : acc;
    end

endmodule

// File: rtl/fcn_ctrl.sv
module fcn_ctrl #(
    parameter int N_IN = 676,
    parameter int CW   = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   in_valid,
    output logic                   in_ready,
    output logic                   take,
    output logic                   finish,
    output logic [CW-1:0]          op_idx,
    output fcn_pkg::fcn_state_e    state
);
    import fcn_pkg::*;

    fcn_state_e state_nx;
    logic       last_beat;

    always_comb begin
        last_beat = (op_idx == CW'(N_IN - 1));
        state_nx  = state;
        unique case (state)
            ST_IDLE:  state_nx = ST_IDLE;
            ST_PRIME: state_nx = ST_RUN;
            ST_RUN:   if (take && last_beat) state_nx = ST_FINAL;
            ST_FINAL: state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_DONE;
            default:  state_nx = ST_IDLE;
        endcase
        if (start) state_nx = ST_PRIME;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     op_idx <= '0;
        else if (start) op_idx <= '0;
        else if (take)  op_idx <= op_idx + 1'b1;
    end

    always_comb begin
        in_ready = (state == ST_RUN);
        take     = in_ready && in_valid && !start;
        finish   = (state == ST_FINAL) && !start;
    end

    AST_PRIME_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !in_ready);                                   // R2
    AST_PRIME_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRIME && !start) |=> in_ready);            // R2
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        op_idx <= CW'(N_IN));                                   // R6

endmodule

// File: rtl/fc_stream_neuron.sv
module fc_stream_neuron #(
    parameter int          N_IN    = 676,
    parameter int          W_SEED  = 1,
    parameter logic [31:0] BIAS    = 32'h0000_0000,
    parameter bit          RELU_EN = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic [31:0] out_data,
    output logic        done
);
    import fcn_pkg::*;

    localparam int AW    = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(N_IN + 1);

    logic          take;
    logic          finish;
    logic [CW-1:0] op_idx;
    logic [31:0]   w_cur;
    logic [31:0]   sum_next;
    logic [31:0]   biased;
    fcn_state_e    state;

    fcn_ctrl #(.N_IN(N_IN), .CW(CW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_ready(in_ready), .take(take), .finish(finish),
        .op_idx(op_idx), .state(state)
    );

    fcn_weight_rom #(.N_IN(N_IN), .W_SEED(W_SEED), .DEPTH(DEPTH), .AW(AW)) rom_i (
        .clk(clk), .rst_n(rst_n), .rd_en(take),
        .rd_addr(op_idx[AW-1:0]), .rd_data(w_cur)
    );

    fcn_mac mac_i (
        .clk(clk), .rst_n(rst_n), .clr(start), .take(take),
        .x_in(in_data), .w_in(w_cur), .sum_next(sum_next)
    );

    always_comb begin
        biased = sum_next + BIAS;
        if (RELU_EN && biased[31]) biased = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data <= '0;
            done     <= 1'b0;
        end else if (start) begin
            out_data <= '0;
            done     <= 1'b0;
        end else if (finish) begin
            out_data <= biased;
            done     <= 1'b1;
        end
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> out_data == '0);                                  // R1
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(out_data)));          // R7
    AST_DONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);                                        // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);                                           // R8

    if (RELU_EN) begin : g_relu_chk
        AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
            done |-> !out_data[31]);                                // R5
    end

endmodule

// File: tb/fc_stream_neuron_tb_top.sv
`timescale 1ns/1ps
module fc_stream_neuron_tb_top;

    localparam int          N      = 7;
    localparam int          SEED   = 123;
    localparam logic [31:0] BIAS_V = 32'hFFFE_8000; // -1.5

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        rdy_a, rdy_b, done_a, done_b;
    logic [31:0] out_a, out_b;

    int checks = 0;
    int fails  = 0;
    logic [31:0] xs [N];

    always #2 clk = ~clk;

    fc_stream_neuron #(.N_IN(N), .W_SEED(SEED), .BIAS(BIAS_V), .RELU_EN(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
        .in_ready(rdy_a), .out_data(out_a), .done(done_a)
    );

    fc_stream_neuron #(.N_IN(N), .W_SEED(SEED), .BIAS(BIAS_V), .RELU_EN(1'b1)) dut_relu_i (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_data(in_data),
        .in_ready(rdy_b), .out_data(out_b), .done(done_b)
    );

    function automatic logic [31:0] ref_weight(int k);
        logic [31:0] h;
        h = k * 32'd40503 + SEED;
        return {{15{h[16]}}, h[16:0]};
    endfunction

    function automatic logic [31:0] ref_sum();
        logic [31:0] acc;
        logic signed [63:0] p;
        acc = '0;
        for (int k = 0; k < N; k++) begin
            p   = $signed(xs[k]) * $signed(ref_weight(k));
            acc = acc + 32'(p >>> 16);
        end
        return acc + BIAS_V;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Full inference using xs, random gaps, garbage during priming and afterwards.
    task automatic run_inf(int gap_pct);
        logic [31:0] r, rr;
        r  = ref_sum();
        rr = r[31] ? 32'h0 : r;
        pulse_start();
        in_valid = 1'b1;
        in_data  = 32'h7FFF_FFFF;              // offered during priming: ignored (R6)
        chk("R2 ready low in priming", {31'b0, rdy_a | rdy_b}, 32'h0);
        chk("R8 done cleared by start", {31'b0, done_a | done_b}, 32'h0);
        @(negedge clk);
        chk("R2 ready after priming", {31'b0, rdy_a & rdy_b}, 32'h1);
        for (int k = 0; k < N; k++) begin
            while (($urandom % 100) < gap_pct) begin
                in_valid = 1'b0;
                in_data  = $urandom;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = xs[k];
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_data  = 32'h1234_5678;             // offered after last: ignored (R7)
        chk("R7 done not yet one cycle early", {31'b0, done_a}, 32'h0);
        chk("R7 ready low after last beat", {31'b0, rdy_a}, 32'h0);
        @(negedge clk);
        chk("R7 done after last beat", {31'b0, done_a & done_b}, 32'h1);
        chk("R3 R4 R5 sum without relu", out_a, r);
        chk("R5 sum with relu", out_b, rr);
        repeat (3) @(negedge clk);
        in_valid = 1'b0;
        chk("R7 result held", out_a, r);
        chk("R7 done held", {31'b0, done_b}, 32'h1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 ready after reset", {31'b0, rdy_a}, 32'h0);
        chk("R1 done after reset", {31'b0, done_a}, 32'h0);
        chk("R1 out after reset", out_a, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle ready", {31'b0, rdy_a}, 32'h0);

        // R4: zero inputs give the bias alone; R5: relu clips it
        for (int k = 0; k < N; k++) xs[k] = '0;
        run_inf(0);

        // R9: unit activations give the sum of weights
        for (int k = 0; k < N; k++) xs[k] = 32'h0001_0000;
        run_inf(0);

        // R3: near full-scale activations force wrap of the accumulator
        for (int k = 0; k < N; k++) xs[k] = (k % 2) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        run_inf(30);

        // R8: restart in mid-run, then a clean inference
        pulse_start();
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            in_valid = 1'b1;
            in_data  = 32'h0050_0000;
            @(negedge clk);
        end
        in_valid = 1'b0;
        for (int k = 0; k < N; k++) xs[k] = 32'h0002_8000 - k * 32'h0000_C000;
        run_inf(10);

        // R6: random activations with random gaps
        for (int t = 0; t < 12; t++) begin
            for (int k = 0; k < N; k++) xs[k] = {{8{1'b0}}, 24'($urandom)} - 32'h0080_0000;
            run_inf(40);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule